// File: doc/BRIEF.md
# Ring-Counter CPU Clock Phase Generator

This block divides a fast master clock down to a CPU clock without a binary counter or comparator. A chain of flip-flops works as a serial-in, parallel-out shift register. Its serial input is the NOR of every stage, so the chain starts itself after reset and steps through a fixed cycle. One of the states in that cycle is all stages at zero; each of the others has exactly one stage set. With the default `DIV` of 9 the chain has eight stages, so an 18 MHz master clock gives a 2 MHz CPU clock.

Two taps on the chain drive a set/clear flip-flop. The early tap sets it and the later tap clears it. The flip-flop's output is the CPU clock `phi2_o`, and `phi2_n_o` is its complement.

The block also gives a phase index with the resolution of one master half-cycle. Other logic can use it to line up with the CPU clock at any of `2*DIV` points in each CPU cycle. An active-high enable freezes the chain and the output flip-flop, which stalls the CPU clock.

Top module: `ring_clk_gen`

## Requirements
- R1: While `rst_ni` is low, `ring_o` is 0, `phi2_o` is 0 and `phi2_n_o` is 1, at once and without waiting for a clock edge.
- R2: The serial input of the chain is 1 exactly when all `ring_o` bits are 0. From the all-zero state, one enabled master rising edge gives `ring_o` = 1 (bit 0 set).
- R3: On each enabled master rising edge, `ring_o` shifts one place toward the most significant bit. With the state index k defined as 0 for all-zero and j+1 for bit j set, `ring_o` steps through k = 0, 1, ..., DIV-1 and back to 0. That is a period of DIV edges (9 by default).
- R4: An enabled edge that sees bit `SET_TAP` (2) of `ring_o` set makes `phi2_o` 1. An enabled edge that sees bit `CLR_TAP` (6) set makes `phi2_o` 0. Set wins if both are seen on the same edge. With the defaults, `phi2_o` is high for 4 master cycles and low for 5, and its rising edges are 9 master cycles apart.
- R5: `phi2_n_o` is always the complement of `phi2_o`.
- R6: While `en_i` is low at a master rising edge, that edge leaves `ring_o` and `phi2_o` unchanged.
- R7: `phase_o` equals 2*k + 1 while the master clock is low and 2*k while it is high, with k as in R3. Its range is therefore 0 to 2*DIV-1 (0 to 17 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master (dot) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; low stalls the CPU clock |
| phi2_o | output | 1 | CPU clock |
| phi2_n_o | output | 1 | Complement of the CPU clock |
| ring_o | output | DIV-1 (8) | Shift-register chain state |
| phase_o | output | $clog2(DIV)+1 (5) | Half-cycle phase index within the CPU cycle |

## Verification
The bench first runs three unbroken CPU periods with the enable held high. This run pins down the state order, the tap positions (from the high and low counts), and the rise-to-rise spacing of `phi2_o`.

A stall sweep then drops the enable for three cycles at each of the nine ring positions. This separates a correct hold from one that slips the chain or the output flip-flop at particular phases, including the set and clear taps.

An alternating enable pattern and a reset in the middle of a run come next. They show whether single-cycle stalls and asynchronous reset bring the chain back to the self-started sequence.

Every cycle, the bench reads `phase_o` once in each half of the master clock. This tells the half-cycle bit apart from the state index.

// File: rtl/ring_clk_pkg.sv
package ring_clk_pkg;
  // master cycles phi2 stays high for a given set/clear tap pair
  function automatic int high_cycles(int set_tap, int clr_tap);
    return clr_tap - set_tap;
  endfunction
endpackage

// File: rtl/rck_chain.sv
module rck_chain #(
  parameter int RING_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [RING_W-1:0] ring_o
);
  logic [RING_W-1:0] ring_q;
  logic              feed;

  assign feed = ~|ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ring_q <= '0;
    else if (en_i) ring_q <= {ring_q[RING_W-2:0], feed};
  end

  assign ring_o = ring_q;

  AST_FEED_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ring_q == '0) |=> ring_q == RING_W'(1)); // R2
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ring_q != '0) |=> ring_q == ($past(ring_q) << 1)); // R3
  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ring_q)); // R3
  AST_RING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ring_q)); // R6
endmodule

// File: rtl/rck_tap_ff.sv
module rck_tap_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic phi2_o
);
  logic phi2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_q <= 1'b0;
    else if (en_i) begin
      if (set_i)      phi2_q <= 1'b1; // set wins
      else if (clr_i) phi2_q <= 1'b0;
    end
  end

  assign phi2_o = phi2_q;

  AST_SET_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && set_i) |=> phi2_q); // R4
  AST_CLR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i && !set_i) |=> !phi2_q); // R4
  AST_PHI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phi2_q)); // R6
endmodule

// File: rtl/rck_phase_enc.sv
module rck_phase_enc #(
  parameter int RING_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RING_W-1:0] ring_i,
  output logic [IDX_W:0]    phase_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int j = RING_W - 1; j >= 0; j--) begin
      if (ring_i[j]) idx = IDX_W'(j + 1);
    end
  end

  // low half of the master cycle is the odd sync point
  assign phase_o = {idx, ~clk_i};

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_o) < 2 * (RING_W + 1)); // R7
endmodule

// File: rtl/ring_clk_gen.sv
module ring_clk_gen #(
  parameter int DIV     = 9,
  parameter int SET_TAP = 2,
  parameter int CLR_TAP = 6,
  localparam int RING_W = DIV - 1,
  localparam int IDX_W  = $clog2(DIV),
  localparam int PH_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              phi2_o,
  output logic              phi2_n_o,
  output logic [RING_W-1:0] ring_o,
  output logic [PH_W-1:0]   phase_o
);
  import ring_clk_pkg::*;

  logic [RING_W-1:0] ring;
  logic              phi2;

  rck_chain #(.RING_W(RING_W)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .ring_o(ring)
  );

  rck_tap_ff u_tap_ff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .set_i (ring[SET_TAP]),
    .clr_i (ring[CLR_TAP]),
    .phi2_o(phi2)
  );

  rck_phase_enc #(.RING_W(RING_W), .IDX_W(IDX_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ring_i (ring),
    .phase_o(phase_o)
  );

  assign phi2_o   = phi2;
  assign phi2_n_o = ~phi2;
  assign ring_o   = ring;

  // duty check: a rise and a fall exactly high_cycles() enabled edges apart
  logic [IDX_W:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hi_cnt <= '0;
    else if (en_i && phi2) hi_cnt <= hi_cnt + 1'b1;
    else if (!phi2)        hi_cnt <= '0;
  end

  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2 && $past(phi2) && !$stable(ring)) |->
      int'(hi_cnt) < high_cycles(SET_TAP, CLR_TAP)); // R4
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!phi2_o && phi2_n_o && ring_o == '0)); // R1
endmodule

// File: tb/ring_clk_gen_bench.sv
module ring_clk_gen_bench;
  localparam int DIV = 9, SET_TAP = 2, CLR_TAP = 6;
  localparam int RING_W = DIV - 1, PH_W = $clog2(DIV) + 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1;
  logic phi2, phi2_n;
  logic [RING_W-1:0] ring;
  logic [PH_W-1:0] phase;

  always #2 clk = ~clk;

  ring_clk_gen #(.DIV(DIV), .SET_TAP(SET_TAP), .CLR_TAP(CLR_TAP)) u_ring_clk_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .phi2_o(phi2), .phi2_n_o(phi2_n), .ring_o(ring), .phase_o(phase)
  );

  int total = 0, bad = 0, k = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RING_W-1:0] exp_ring(int kk);
    return kk == 0 ? '0 : RING_W'(1) << (kk - 1);
  endfunction

  function automatic bit exp_phi(int kk);
    return kk >= SET_TAP + 2 && kk <= CLR_TAP + 1;
  endfunction

  // one master cycle: advance model, check high half, then low half
  task automatic step();
    logic en_s;
    @(posedge clk);
    en_s = en;
    if (!rst_n) k = 0;
    else if (en_s) k = (k + 1) % DIV;
    #1;
    chk(ring == exp_ring(k), en_s ? "R3" : "R6", int'(ring), int'(exp_ring(k)));
    chk(phi2 == exp_phi(k), en_s ? "R4" : "R6", int'(phi2), int'(exp_phi(k)));
    chk(phi2_n == ~phi2, "R5", int'(phi2_n), int'(~phi2));
    chk(int'(phase) == 2 * k, "R7", int'(phase), 2 * k);
    @(negedge clk);
    #1;
    chk(int'(phase) == 2 * k + 1, "R7", int'(phase), 2 * k + 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last_rise, hi, lo;
    bit prev;
    // R1 reset state, both clock halves
    @(posedge clk); #1;
    chk(ring == '0 && !phi2 && phi2_n, "R1", int'(ring), 0);
    chk(int'(phase) == 0, "R1", int'(phase), 0);
    @(negedge clk); #1;
    chk(int'(phase) == 1, "R1", int'(phase), 1);
    rst_n = 1'b1;
    // R2 self start
    step();
    chk(ring == RING_W'(1), "R2", int'(ring), 1);
    // three free-running periods: period and duty
    last_rise = -1; hi = 0; lo = 0; prev = phi2;
    for (int i = 0; i < 3 * DIV; i++) begin
      step();
      if (phi2 && !prev) begin
        if (last_rise >= 0) chk(i - last_rise == DIV, "R4", i - last_rise, DIV);
        last_rise = i;
      end
      if (i >= DIV && i < 2 * DIV) begin
        if (phi2) hi++; else lo++;
      end
      if (k == 1 && i > 0) chk(ring == RING_W'(1), "R2", int'(ring), 1);
      prev = phi2;
    end
    chk(hi == CLR_TAP - SET_TAP, "R4", hi, CLR_TAP - SET_TAP);
    chk(lo == DIV - (CLR_TAP - SET_TAP), "R4", lo, DIV - (CLR_TAP - SET_TAP));
    // stall sweep: hold at every ring position
    for (int s = 0; s < DIV; s++) begin
      en = 1'b0;
      for (int h = 0; h < 3; h++) step();
      en = 1'b1;
      step();
    end
    // alternating enable
    for (int i = 0; i < 4 * DIV; i++) begin
      en = (i % 2) == 0;
      step();
    end
    en = 1'b1;
    for (int i = 0; i < 4; i++) step();
    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk(ring == '0 && !phi2 && phi2_n, "R1", int'(ring), 0);
    k = 0;
    step();
    rst_n = 1'b1;
    for (int i = 0; i < 2 * DIV; i++) step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule